// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block drives a bank of pulse-width-modulated outputs, one per channel, from a small register window. Each channel owns a pulse word and a frame word. The pulse word gives the count at which the output enters its active phase and the count at which it leaves it. The frame word gives the period length in counter ticks, the output level for each phase, and a prescaler code that sets how many clock cycles make one counter tick. A shared enable word, with separate set and clear write addresses, turns channels on and off without a read-modify-write.

Software writes the pulse word first and then the frame word. The frame write arms the pair. A running channel takes the armed pair only where one period ends and the next begins, so no period is ever a mix of old and new settings. A stopped channel takes an armed pair on the next clock, so enabling it starts straight away with the latest settings. Reads of a channel's words always return the settings that are committed and in use, not the staged ones.

Top module: `mpwm_top`

## Requirements
- R1: After reset every output is low, the enable word reads 0 and every pulse and frame word reads 0.
- R2: The enable word reads at offset 0x00. A write at 0x04 sets each enable bit whose data bit is 1, and a write at 0x08 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value, and the change is visible on the clock after the write.
- R3: A disabled channel drives its output low, starting on the clock edge that clears its enable bit.
- R4: On the clock edge that sets its enable bit, a channel starts a period with counter 0. The counter advances by one per prescaler tick. The channel is in its active phase while start <= counter < end, where start is pulse-word bits 15:0 and end is pulse-word bits 31:16, and in its inactive phase otherwise.
- R5: Frame-word bits 22:20 select the clock cycles per counter tick. Codes 0 to 7 give 1, 2, 4, 8, 16, 64, 256 and 1024 cycles.
- R6: Frame-word bits 15:0 hold the period length P in ticks. The counter runs 0 to P-1 and then returns to 0, and a P of 0 acts as 1.
- R7: Frame-word bits 17:16 set the level driven in the active phase and bits 19:18 the level driven in the inactive phase. Code 3 drives high, code 2 drives low, and codes 0 and 1 keep the level last driven (low right after enable).
- R8: A pulse-word write alone changes nothing in use. A frame-word write arms the staged pair, and on a running channel the pair comes into use only on the edge where the counter returns to 0. Reads return the words in use.
- R9: On a disabled channel an armed pair comes into use on the next clock edge, and it is therefore in use from the first period after enable.
- R10: The pulse word of channel n sits at offset 0x10 + 0x20*n and the frame word at offset 0x20 + 0x20*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A wrong prescaler length or period compare shows on the output as a phase edge one or more cycles off, inside the first period after enable. A wrong commit rule shows as a period whose length or duty is neither the old setting nor the new one, or as a read-back of a staged word before the boundary. A stuck or cross-wired enable bit shows on the next clock, both on the output and in the enable word read-back. The bench holds a model of each channel that is built from the requirements and compares every output bit on every cycle, so any of these faults is seen in the cycle it first appears.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int MAX_CH   = 8;
    localparam int CNT_W    = 16;
    localparam int DSEL_W   = 3;
    localparam int PRE_W    = 11;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_SET  = 'h04;
    localparam int OFF_CLR  = 'h08;
    localparam int OFF_PUL  = 'h10;
    localparam int OFF_FRM  = 'h20;
    localparam int STRIDE   = 'h20;

    // pulse word: end of active phase in the upper half, start in the lower
    typedef struct packed {
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] start;
    } pul_t;

    // frame word
    typedef struct packed {
        logic [8:0]        rsv;
        logic [DSEL_W-1:0] dsel;
        logic [1:0]        lvl_idle;
        logic [1:0]        lvl_busy;
        logic [CNT_W-1:0]  len;
    } frm_t;

    function automatic int pul_off(input int ch);
        return OFF_PUL + STRIDE * ch;
    endfunction

    function automatic int frm_off(input int ch);
        return OFF_FRM + STRIDE * ch;
    endfunction

    // cycles per tick: codes below 5 double, codes above quadruple
    function automatic logic [PRE_W-1:0] tick_len(input logic [DSEL_W-1:0] code);
        logic [3:0] sh;
        if (code < 3'd5) sh = {1'b0, code};
        else             sh = ({1'b0, code} << 1) - 4'd4;
        return PRE_W'(1) << sh;
    endfunction

endpackage

// File: rtl/mpwm_presc.sv
module mpwm_presc
    import mpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] len,
    output logic             tick
);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q >= len - PRE_W'(1));
        pre_d = pre_q + PRE_W'(1);
        if (!run || tick) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
    import mpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  pul_t stg_pul,
    input  frm_t stg_frm,
    input  logic arm,
    output pul_t com_pul,
    output frm_t com_frm,
    output logic bnd,
    output logic pwm
);

    typedef struct packed {
        logic             armed;
        pul_t             pul;
        frm_t             frm;
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } cst_t;

    cst_t s_d, s_q;
    logic tick;
    logic wrap;
    logic commit;
    logic in_busy;
    logic [1:0] code;
    logic lvl;

    mpwm_presc u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en),
        .len  (tick_len(s_q.frm.dsel)),
        .tick (tick)
    );

    always_comb begin
        s_d     = s_q;
        wrap    = tick && (({1'b0, s_q.cnt} + 17'd1) >= {1'b0, s_q.frm.len});
        commit  = s_q.armed && (!en || wrap);

        if (!en || wrap) s_d.cnt = '0;
        else if (tick)   s_d.cnt = s_q.cnt + CNT_W'(1);

        if (commit) begin
            s_d.pul = stg_pul;
            s_d.frm = stg_frm;
        end

        if (arm)         s_d.armed = 1'b1;
        else if (commit) s_d.armed = 1'b0;

        in_busy = (s_q.cnt >= s_q.pul.start) && (s_q.cnt < s_q.pul.stop);
        code    = in_busy ? s_q.frm.lvl_busy : s_q.frm.lvl_idle;
        lvl     = code[1] ? code[0] : s_q.hold;
        s_d.hold = en ? lvl : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm     = en & lvl;
    assign bnd     = wrap;
    assign com_pul = s_q.pul;
    assign com_frm = s_q.frm;

endmodule

// File: rtl/mpwm_regs.sv
module mpwm_regs
    import mpwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [NCH-1:0]    en,
    output pul_t [NCH-1:0]    stg_pul,
    output frm_t [NCH-1:0]    stg_frm,
    output logic [NCH-1:0]    arm
);

    typedef struct packed {
        logic [NCH-1:0] en;
        pul_t [NCH-1:0] pul;
        frm_t [NCH-1:0] frm;
    } rst_t;

    rst_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        arm = '0;
        if (wr) begin
            if (addr == ADDR_W'(OFF_SET)) r_d.en = r_q.en | wdata[NCH-1:0];
            if (addr == ADDR_W'(OFF_CLR)) r_d.en = r_q.en & ~wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(pul_off(c))) begin
                    r_d.pul[c] = wdata;
                end
                if (addr == ADDR_W'(frm_off(c))) begin
                    r_d.frm[c]     = wdata;
                    r_d.frm[c].rsv = '0;
                    arm[c]         = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en      = r_q.en;
    assign stg_pul = r_q.pul;
    assign stg_frm = r_q.frm;

endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
    import mpwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int MAP_TOP = OFF_FRM + STRIDE * (NCH - 1);

    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] ch_arm;
    logic [NCH-1:0] ch_bnd;
    pul_t [NCH-1:0] stg_pul;
    frm_t [NCH-1:0] stg_frm;
    pul_t [NCH-1:0] com_pul;
    frm_t [NCH-1:0] com_frm;

    mpwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .en     (ch_en),
        .stg_pul(stg_pul),
        .stg_frm(stg_frm),
        .arm    (ch_arm)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mpwm_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (ch_en[g]),
            .stg_pul(stg_pul[g]),
            .stg_frm(stg_frm[g]),
            .arm    (ch_arm[g]),
            .com_pul(com_pul[g]),
            .com_frm(com_frm[g]),
            .bnd    (ch_bnd[g]),
            .pwm    (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = 32'(ch_en);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(pul_off(c))) bus_rdata = com_pul[c];
            if (bus_addr == ADDR_W'(frm_off(c))) bus_rdata = com_frm[c];
        end
    end

    initial begin
        if (NCH < 1 || NCH > MAX_CH || MAP_TOP >= (1 << ADDR_W)) begin
            $display("mpwm_top: NCH=%0d does not fit the %0d-bit address map", NCH, ADDR_W);
        end
    end

endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NCH-1:0]         pwm_out,
    input logic [NCH-1:0]         en,
    input logic [NCH-1:0][31:0]   com_pul,
    input logic [NCH-1:0][31:0]   com_frm,
    input logic [NCH-1:0]         bnd
);

    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~en) == '0);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h04)) |=>
        ((en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h08)) |=>
        ((en & $past(bus_wdata[NCH-1:0])) == '0));

    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'('h04) || bus_addr == ADDR_W'('h08))) |=>
        ((en & ~$past(bus_wdata[NCH-1:0])) == ($past(en) & ~$past(bus_wdata[NCH-1:0]))));

    for (genvar g = 0; g < NCH; g++) begin : g_ck
        p_commit_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(com_frm[g]) || !$stable(com_pul[g])) |->
            ($past(bnd[g]) || !$past(en[g])));
    end

endmodule

bind mpwm_top mpwm_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pwm_out  (pwm_out),
    .en       (ch_en),
    .com_pul  (com_pul),
    .com_frm  (com_frm),
    .bnd      (ch_bnd)
);

// File: tb/sim_mpwm_top.sv
`timescale 1ns/1ps
module sim_mpwm_top;

    localparam int NCH = 4;
    localparam int AW  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    mpwm_top #(.NCH(NCH), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // reference model built from the requirements
    logic [NCH-1:0] m_en;
    logic [31:0] m_cpul [NCH];
    logic [31:0] m_cfrm [NCH];
    logic [31:0] m_spul [NCH];
    logic [31:0] m_sfrm [NCH];
    logic        m_arm  [NCH];
    int unsigned m_t    [NCH];
    logic        m_lvl  [NCH];
    logic [NCH-1:0] exp_q[$];

    function automatic int unsigned cyc_per_tick(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd4: return 16;
            3'd5: return 64;
            3'd6: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [31:0] frm_word(input int len, input int busy, input int idle, input int dsel);
        return (32'(dsel) << 20) | (32'(idle) << 18) | (32'(busy) << 16) | 32'(len);
    endfunction

    function automatic logic [31:0] pul_word(input int start, input int stop);
        return (32'(stop) << 16) | 32'(start);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0;
            for (int c = 0; c < NCH; c++) begin
                m_cpul[c] = 0; m_cfrm[c] = 0; m_spul[c] = 0; m_sfrm[c] = 0;
                m_arm[c] = 0; m_t[c] = 0; m_lvl[c] = 0;
            end
        end else begin
            logic [NCH-1:0] e;
            logic [NCH-1:0] old_en;
            logic nh [NCH];
            old_en = m_en;
            for (int c = 0; c < NCH; c++) begin
                int unsigned d, p, len;
                logic cm;
                nh[c] = old_en[c] ? m_lvl[c] : 1'b0;
                cm = 1'b0;
                if (!old_en[c]) begin
                    m_t[c] = 0;
                    cm = m_arm[c];
                end else begin
                    d = cyc_per_tick(m_cfrm[c][22:20]);
                    p = (m_cfrm[c][15:0] == 0) ? 1 : int'(m_cfrm[c][15:0]);
                    len = d * p;
                    if (m_t[c] + 1 >= len) begin
                        m_t[c] = 0;
                        cm = m_arm[c];
                    end else begin
                        m_t[c] = m_t[c] + 1;
                    end
                end
                if (cm) begin
                    m_cpul[c] = m_spul[c];
                    m_cfrm[c] = m_sfrm[c];
                    m_arm[c]  = 1'b0;
                end
            end
            if (bus_wr) begin
                if (bus_addr == AW'('h04)) m_en = m_en | bus_wdata[NCH-1:0];
                if (bus_addr == AW'('h08)) m_en = m_en & ~bus_wdata[NCH-1:0];
                for (int c = 0; c < NCH; c++) begin
                    if (bus_addr == AW'('h10 + 'h20 * c)) m_spul[c] = bus_wdata;
                    if (bus_addr == AW'('h20 + 'h20 * c)) begin
                        m_sfrm[c] = bus_wdata & 32'h007F_FFFF;
                        m_arm[c]  = 1'b1;
                    end
                end
            end
            for (int c = 0; c < NCH; c++) begin
                int unsigned cnt;
                logic [1:0] code;
                logic lv;
                cnt  = m_t[c] / cyc_per_tick(m_cfrm[c][22:20]);
                code = (cnt >= m_cpul[c][15:0] && cnt < m_cpul[c][31:16])
                       ? m_cfrm[c][17:16] : m_cfrm[c][19:18];
                lv   = code[1] ? code[0] : nh[c];
                m_lvl[c] = lv;
                e[c] = m_en[c] & lv;
            end
            exp_q.push_back(e);
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // monitor: pops one expected output word per cycle
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [NCH-1:0] e;
            e = exp_q.pop_front();
            chk(cur_req, 32'(pwm_out), 32'(e));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    // kind 0: enable word, 1: pulse word, 2: frame word; expected from the model
    task automatic rd(input int kind, input int ch, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr = (kind == 0) ? AW'(0) : (kind == 1) ? AW'('h10 + 'h20 * ch) : AW'('h20 + 'h20 * ch);
        #1;
        exp = (kind == 0) ? 32'(m_en) : (kind == 1) ? m_cpul[ch] : m_cfrm[ch];
        chk(req, bus_rdata, exp);
    endtask

    task automatic rd_lit(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        #1 chk("R1", 32'(pwm_out), 0);
        rd_lit('h00, 0, "R1");
        rd_lit('h10, 0, "R1");
        rd_lit('h20, 0, "R1");

        // R9: disabled channel commits an armed pair on the next clock
        cur_req = "R9";
        wr('h10, pul_word(0, 2));
        rd_lit('h10, 0, "R8 pulse alone not in use");
        wr('h20, frm_word(5, 3, 2, 0));
        idle(1);
        rd_lit('h20, frm_word(5, 3, 2, 0), "R9");
        rd_lit('h10, pul_word(0, 2), "R9");

        // R2: set and clear aliases
        cur_req = "R2";
        wr('h04, 32'h5);
        rd_lit('h00, 32'h5, "R2 set");
        wr('h08, 32'h1);
        rd_lit('h00, 32'h4, "R2 clear");
        wr('h04, 32'h0);
        rd_lit('h00, 32'h4, "R2 zero set");
        wr('h08, 32'h0);
        rd_lit('h00, 32'h4, "R2 zero clear");

        // R4/R6: channel 0 runs 5-tick periods, active for counts 0..1
        cur_req = "R4";
        wr('h04, 32'h1);
        idle(20);

        // R5: channel 2 with 4 cycles per tick, active for count 1
        cur_req = "R5";
        wr('h50, pul_word(1, 2));
        wr('h60, frm_word(3, 3, 2, 2));
        idle(40);
        rd(2, 2, "R10 frame stride");
        rd(1, 2, "R10 pulse stride");

        // R8: mid-period update of channel 0
        cur_req = "R8";
        wr('h10, pul_word(0, 4));
        idle(12);
        rd_lit('h10, pul_word(0, 2), "R8 staged pulse not in use");
        wr('h20, frm_word(8, 3, 2, 0));
        rd(2, 0, "R8 frame read before boundary");
        idle(20);
        rd_lit('h10, pul_word(0, 4), "R8 committed pulse");
        rd_lit('h20, frm_word(8, 3, 2, 0), "R8 committed frame");

        // R7: inverted levels on channel 1, hold code on channel 3
        cur_req = "R7";
        wr('h30, pul_word(1, 3));
        wr('h40, frm_word(6, 2, 3, 1));
        wr('h04, 32'h2);
        idle(30);
        wr('h70, pul_word(0, 2));
        wr('h80, frm_word(4, 3, 0, 0));
        wr('h04, 32'h8);
        idle(20);
        #1 chk("R7 hold keeps high", 32'(pwm_out[3]), 1);
        rd(2, 3, "R10 frame ch3");

        // R6: zero period length acts as one tick
        cur_req = "R6";
        wr('h10, pul_word(0, 1));
        wr('h20, frm_word(0, 3, 2, 0));
        idle(12);
        #1 chk("R6 len 0 always active", 32'(pwm_out[0]), 1);

        // R5: sweep all prescaler codes on channel 1
        cur_req = "R5";
        for (int k = 0; k < 8; k++) begin
            wr('h30, pul_word(0, 1));
            wr('h40, frm_word(2, 3, 2, k));
            idle(4 * 1024 + 8);
            rd(2, 1, "R5 code committed");
        end

        // R3: disable drives outputs low
        cur_req = "R3";
        wr('h08, 32'hF);
        #1 chk("R3 off low", 32'(pwm_out), 0);
        idle(6);
        rd_lit('h00, 0, "R3 enables cleared");

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule